// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Timer

This block drives three pulse-width-modulated phase signals that share one switching period. Each phase pulse sits in the middle of the period, so the three pulses of a cycle are symmetric about the same center point. A one-clock strobe marks the first clock of every switching cycle, so that sampling or control logic elsewhere can lock onto the PWM grid.

Software programs the block through a small write port. One register holds the period in clocks. Three registers hold the on-time of each phase in clocks. The duty registers are shadow copies. Their values move into the active set only at a cycle boundary, and only once all three phases have been rewritten since the last update. The period and the switching edges for the next cycle are worked out a fixed number of clocks before the boundary. A write that arrives inside that window is carried over to the cycle after.

Top module: `pwm3c_timer`

## Requirements
- R1: Two consecutive sync pulses are exactly P clocks apart, where P is the active 12-bit period value. A period value below MIN_PERIOD (default 8) is treated as MIN_PERIOD.
- R2: `sync_o` is high for exactly one clock, at position 0 of each cycle. It is low at every other position and while reset is asserted.
- R3: In every cycle, each phase is high for min(D, P) clocks, where D is its active duty value. D = 0 gives no pulse at all.
- R4: A pulse with 0 < D < P begins at cycle position floor((P − D) / 2), with position 0 being the sync clock, and stays high for D consecutive clocks. D ≥ P holds the phase high from position 0 to position P − 1.
- R5: Write port selector encoding: 0 = period, 1 = phase A duty, 2 = phase B duty, 3 = phase C duty. A write never changes the outputs of the cycle in progress. The active period and duties change only at the boundary between two cycles.
- R6: New duty values become active only when all three duty registers have been written since the last duty update. Values from a partial set of writes are held until the missing channels are written.
- R7: A write counts toward the next boundary only if it is captured at cycle position P − LEAD − 1 or earlier (LEAD = 4 clocks). A write captured at position P − LEAD or later takes effect one cycle later. This applies to both period and duty writes.
- R8: While reset is held, all phase outputs and `sync_o` are low. Reset returns the block to cycle position 0 with period RST_PERIOD (default 64), all duties 0, and all written flags cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 period, 1 A, 2 B, 3 C) |
| wr_data | input | 12 | Write value, in clocks |
| phase_o | output | 3 | Phase pulses, bit 0 = A, bit 1 = B, bit 2 = C, active high |
| sync_o | output | 1 | One-clock cycle-start strobe |

## Verification
The bench targets these edge cases:

- **Duty extremes.** Duties of zero, equal to the period, above the period, and odd differences to the period. A wrong comparison would give a one-clock sliver or a pulse shifted by one position.
- **Partial updates.** Writes that cover only some channels must leave the old duties running. A design that applies them early would show the new width a cycle too soon.
- **Late writes.** Writes that land exactly on the last legal position and exactly on the first late position, for both duties and the period. A design with an off-by-one window would apply or drop the update in the wrong cycle.
- **Period limits.** A period below the minimum, and the full-scale 12-bit period.
- **Mid-run reset.** Reset asserted during operation must restore the default period with silent outputs.

// File: rtl/pwm3_pkg.sv
`timescale 1ns/1ps
package pwm3_pkg;

    localparam int CW  = 12;
    localparam int NPH = 3;

    typedef logic [CW-1:0] cval_t;

    typedef enum logic [1:0] {
        REG_PERIOD = 2'd0,
        REG_DUTY_A = 2'd1,
        REG_DUTY_B = 2'd2,
        REG_DUTY_C = 2'd3
    } reg_sel_e;

    // Cycle positions where a phase turns on (inclusive) and off (exclusive)
    typedef struct packed {
        cval_t rise;
        cval_t fall;
    } span_t;

    function automatic span_t span_of(cval_t per, cval_t duty);
        span_t s;
        if (duty == '0) begin
            s.rise = per;
            s.fall = per;
        end else if (duty >= per) begin
            s.rise = '0;
            s.fall = per;
        end else begin
            s.rise = (per - duty) >> 1;
            s.fall = s.rise + duty;
        end
        return s;
    endfunction

    function automatic cval_t clamp_period(cval_t p, cval_t floor_v);
        return (p < floor_v) ? floor_v : p;
    endfunction

endpackage

// File: rtl/pwm3_counter.sv
`timescale 1ns/1ps
module pwm3_counter
    import pwm3_pkg::*;
#(
    parameter int RST_PERIOD = 64,
    parameter int LEAD       = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  cval_t next_period,
    output cval_t pos,
    output cval_t period,
    output logic  arm,
    output logic  wrap,
    output logic  sync
);

    localparam cval_t RST_P  = cval_t'(RST_PERIOD);
    localparam cval_t LEAD_V = cval_t'(LEAD);
    localparam cval_t ONE    = cval_t'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos    <= '0;
            period <= RST_P;
        end else if (wrap) begin
            pos    <= '0;
            period <= next_period;
        end else begin
            pos    <= pos + ONE;
        end
    end

    assign wrap = (pos == period - ONE);
    assign arm  = (pos == period - LEAD_V);
    assign sync = (pos == '0) && !rst;

endmodule

// File: rtl/pwm3_shadow.sv
`timescale 1ns/1ps
module pwm3_shadow
    import pwm3_pkg::*;
#(
    parameter int RST_PERIOD = 64,
    parameter int MIN_PERIOD = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  cval_t             wr_data,
    input  logic              arm,
    input  logic              wrap,
    output cval_t             next_period,
    output span_t [NPH-1:0]   act_span,
    output logic  [NPH-1:0]   written
);

    localparam cval_t RST_P = cval_t'(RST_PERIOD);
    localparam cval_t MIN_P = cval_t'(MIN_PERIOD);

    cval_t                per_sh;
    cval_t  [NPH-1:0]     duty_sh;
    cval_t  [NPH-1:0]     act_duty;
    cval_t  [NPH-1:0]     pend_duty;
    span_t  [NPH-1:0]     pend_span;
    logic   [NPH-1:0]     wr_hit;
    logic                 commit;
    cval_t                per_new;
    cval_t  [NPH-1:0]     duty_src;
    span_t  [NPH-1:0]     span_new;
    reg_sel_e             sel;

    assign sel    = reg_sel_e'(wr_sel);
    assign commit = arm && (&written);

    genvar g;
    generate
        for (g = 0; g < NPH; g++) begin : g_ch
            assign wr_hit[g]   = wr_en && (wr_sel == 2'(g + 1));
            assign duty_src[g] = commit ? duty_sh[g] : act_duty[g];
            assign span_new[g] = span_of(per_new, duty_src[g]);
        end
    endgenerate

    assign per_new = clamp_period(per_sh, MIN_P);

    always_ff @(posedge clk) begin
        if (rst) begin
            per_sh      <= RST_P;
            duty_sh     <= '0;
            written     <= '0;
            act_duty    <= '0;
            pend_duty   <= '0;
            next_period <= RST_P;
            for (int i = 0; i < NPH; i++) begin
                pend_span[i] <= span_of(RST_P, '0);
                act_span[i]  <= span_of(RST_P, '0);
            end
        end else begin
            if (wr_en && sel == REG_PERIOD) per_sh <= wr_data;
            for (int i = 0; i < NPH; i++) begin
                if (wr_hit[i]) duty_sh[i] <= wr_data;
            end
            written <= (commit ? '0 : written) | wr_hit;
            if (arm) begin
                next_period <= per_new;
                pend_duty   <= duty_src;
                pend_span   <= span_new;
            end
            if (wrap) begin
                act_span <= pend_span;
                act_duty <= pend_duty;
            end
        end
    end

endmodule

// File: rtl/pwm3_compare.sv
`timescale 1ns/1ps
module pwm3_compare
    import pwm3_pkg::*;
(
    input  cval_t             pos,
    input  span_t [NPH-1:0]   act_span,
    output logic  [NPH-1:0]   phase
);

    genvar g;
    generate
        for (g = 0; g < NPH; g++) begin : g_cmp
            assign phase[g] = (pos >= act_span[g].rise) && (pos < act_span[g].fall);
        end
    endgenerate

endmodule

// File: rtl/pwm3c_timer.sv
`timescale 1ns/1ps
module pwm3c_timer
    import pwm3_pkg::*;
#(
    parameter int RST_PERIOD = 64,
    parameter int LEAD       = 4,
    parameter int MIN_PERIOD = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [11:0] wr_data,
    output logic [2:0]  phase_o,
    output logic        sync_o
);

    cval_t             pos;
    cval_t             cur_period;
    cval_t             next_period;
    logic              arm;
    logic              wrap;
    span_t [NPH-1:0]   act_span;
    logic  [NPH-1:0]   written;

    pwm3_counter #(
        .RST_PERIOD (RST_PERIOD),
        .LEAD       (LEAD)
    ) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .next_period (next_period),
        .pos         (pos),
        .period      (cur_period),
        .arm         (arm),
        .wrap        (wrap),
        .sync        (sync_o)
    );

    pwm3_shadow #(
        .RST_PERIOD (RST_PERIOD),
        .MIN_PERIOD (MIN_PERIOD)
    ) u_shd (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .arm         (arm),
        .wrap        (wrap),
        .next_period (next_period),
        .act_span    (act_span),
        .written     (written)
    );

    pwm3_compare u_cmp (
        .pos      (pos),
        .act_span (act_span),
        .phase    (phase_o)
    );

endmodule

// File: rtl/pwm3c_timer_chk.sv
`timescale 1ns/1ps
module pwm3c_timer_chk
    import pwm3_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             sync_o,
    input logic [2:0]       phase_o,
    input cval_t            pos,
    input cval_t            period,
    input logic             wrap,
    input span_t [NPH-1:0]  act_span
);

    a_r1_pos_bound: assert property (@(posedge clk) disable iff (rst)
        pos < period);

    a_r1_wrap_to_sync: assert property (@(posedge clk) disable iff (rst)
        wrap |=> sync_o);

    a_r2_sync_single: assert property (@(posedge clk) disable iff (rst)
        sync_o |=> !sync_o);

    a_r5_span_hold: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(act_span));

    a_r8_reset_quiet: assert property (@(posedge clk)
        rst |=> (phase_o == 3'b000));

endmodule

bind pwm3c_timer pwm3c_timer_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .sync_o   (sync_o),
    .phase_o  (phase_o),
    .pos      (pos),
    .period   (cur_period),
    .wrap     (wrap),
    .act_span (act_span)
);

// File: tb/pwm3c_timer_test.sv
`timescale 1ns/1ps
module pwm3c_timer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [11:0] wr_data = 12'd0;
    logic [2:0]  phase;
    logic        sync;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    pwm3c_timer uut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .phase_o (phase),
        .sync_o  (sync)
    );

    // {period, duty A, duty B, duty C}
    localparam int NV = 7;
    localparam logic [47:0] VEC [NV] = '{
        {12'd20,   12'd10,   12'd5,    12'd0},
        {12'd9,    12'd1,    12'd2,    12'd3},
        {12'd21,   12'd4,    12'd7,    12'd30},
        {12'd16,   12'd15,   12'd2,    12'd8},
        {12'd40,   12'd0,    12'd40,   12'd13},
        {12'd4095, 12'd4095, 12'd2000, 12'd1},
        {12'd20,   12'd20,   12'd19,   12'd1}
    };

    int sch_n = 0;
    int sch_pos [4];
    int sch_sel [4];
    int sch_dat [4];
    int cp, ca, cb, cc;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_rise(int p, int d);
        if (d == 0) return -1;
        if (d >= p) return 0;
        return (p - d) / 2;
    endfunction

    function automatic int exp_width(int p, int d);
        return (d >= p) ? p : d;
    endfunction

    function automatic int eff_period(int p);
        return (p < 8) ? 8 : p;
    endfunction

    task automatic sched(input int pos, input int sel, input int dat);
        sch_pos[sch_n] = pos;
        sch_sel[sch_n] = sel;
        sch_dat[sch_n] = dat;
        sch_n++;
    endtask

    // Entered at the sample point of position 0; leaves at the next position 0.
    task automatic run_cycle(input int p, input int ea, input int eb, input int ec,
                             input string tag);
        int wid [3];
        int first [3];
        int ed [3];
        int extra;
        ed[0] = ea; ed[1] = eb; ed[2] = ec;
        extra = 0;
        for (int ch = 0; ch < 3; ch++) begin
            wid[ch] = 0;
            first[ch] = -1;
        end
        for (int pos = 0; pos < p; pos++) begin
            wr_en = 1'b0;
            for (int k = 0; k < sch_n; k++) begin
                if (sch_pos[k] == pos) begin
                    wr_en   = 1'b1;
                    wr_sel  = sch_sel[k][1:0];
                    wr_data = sch_dat[k][11:0];
                end
            end
            if (pos > 0 && sync) extra++;
            for (int ch = 0; ch < 3; ch++) begin
                if (phase[ch]) begin
                    wid[ch]++;
                    if (first[ch] < 0) first[ch] = pos;
                end
            end
            @(negedge clk);
        end
        wr_en = 1'b0;
        sch_n = 0;
        check(sync == 1'b1, "R1", {tag, " sync after period"}, int'(sync), 1);
        check(extra == 0, "R2", {tag, " extra sync pulses"}, extra, 0);
        for (int ch = 0; ch < 3; ch++) begin
            check(wid[ch] == exp_width(p, ed[ch]), "R3", $sformatf("%s width ch%0d", tag, ch),
                  wid[ch], exp_width(p, ed[ch]));
            check(first[ch] == exp_rise(p, ed[ch]), "R4", $sformatf("%s rise ch%0d", tag, ch),
                  first[ch], exp_rise(p, ed[ch]));
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R8: reset state
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(phase == 3'b000, "R8", "phases in reset", int'(phase), 0);
        check(sync == 1'b0, "R8", "sync in reset", int'(sync), 0);
        rst = 1'b0;
        #1;
        check(sync == 1'b1, "R2", "sync at first position", int'(sync), 1);
        cp = 64; ca = 0; cb = 0; cc = 0;

        // Vector table: load all four registers early, then measure the new cycle
        for (int v = 0; v < NV; v++) begin
            sched(0, 0, int'(VEC[v][47:36]));
            sched(1, 1, int'(VEC[v][35:24]));
            sched(2, 2, int'(VEC[v][23:12]));
            sched(3, 3, int'(VEC[v][11:0]));
            run_cycle(cp, ca, cb, cc, "R5 old values during load");
            cp = eff_period(int'(VEC[v][47:36]));
            ca = int'(VEC[v][35:24]);
            cb = int'(VEC[v][23:12]);
            cc = int'(VEC[v][11:0]);
            run_cycle(cp, ca, cb, cc, $sformatf("vector %0d", v));
        end

        // R6: partial writes are held until the missing channel is written
        sched(1, 1, 6);
        sched(2, 2, 11);
        run_cycle(cp, ca, cb, cc, "R6 partial write cycle");
        sched(1, 3, 2);
        run_cycle(cp, ca, cb, cc, "R6 partial held");
        ca = 6; cb = 11; cc = 2;
        run_cycle(cp, ca, cb, cc, "R6 completed set");

        // R7: last write lands on position P-4, deferred one cycle
        sched(14, 1, 8);
        sched(15, 2, 9);
        sched(16, 3, 10);
        run_cycle(cp, ca, cb, cc, "R7 late write cycle");
        run_cycle(cp, ca, cb, cc, "R7 late deferred");
        ca = 8; cb = 9; cc = 10;
        run_cycle(cp, ca, cb, cc, "R7 late applied");

        // R7: last write on position P-5 is still in time
        sched(13, 1, 4);
        sched(14, 2, 5);
        sched(15, 3, 12);
        run_cycle(cp, ca, cb, cc, "R7 legal write cycle");
        ca = 4; cb = 5; cc = 12;
        run_cycle(cp, ca, cb, cc, "R7 legal applied");

        // R7: late period write deferred one cycle
        sched(16, 0, 30);
        run_cycle(cp, ca, cb, cc, "R7 period late write");
        run_cycle(cp, ca, cb, cc, "R7 period deferred");
        cp = 30;
        run_cycle(cp, ca, cb, cc, "R7 period applied");

        // R1: period below minimum clamps
        sched(0, 0, 3);
        sched(1, 1, 8);
        sched(2, 2, 3);
        sched(3, 3, 5);
        run_cycle(cp, ca, cb, cc, "R1 clamp load");
        cp = 8; ca = 8; cb = 3; cc = 5;
        run_cycle(cp, ca, cb, cc, "R1 clamped period");

        // R8: mid-run reset restores defaults
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(phase == 3'b000, "R8", "phases in mid-run reset", int'(phase), 0);
        check(sync == 1'b0, "R8", "sync in mid-run reset", int'(sync), 0);
        rst = 1'b0;
        #1;
        check(sync == 1'b1, "R8", "sync after reset", int'(sync), 1);
        cp = 64; ca = 0; cb = 0; cc = 0;
        run_cycle(cp, ca, cb, cc, "R8 defaults after reset");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule